// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting FIFO Engine

This block sits between a byte-wide NAND data port and a host register port. It stages transfers through a 64-byte FIFO. A start command carries a byte length, a direction and an optional DMA flag.

In read direction the engine fetches flash bytes into the FIFO. The host drains it with 32-bit pops. In write direction the host fills the FIFO with 16-bit pushes, and the engine posts the bytes to the flash. Both sides may run at the same time, so the host keeps streaming while the flash side runs at its own pace.

A 32-bit status word reports two fields. The first is the FIFO byte count: the bytes available in read direction, or the free space in write direction. The second is the number of bytes the flash side still has to move. When the DMA flag is set, the engine pulses a request for each full 64-byte frame. A start that arrives while a transfer is loaded is refused. The engine stays loaded until a stop command clears it.

Top module: `nand_pf_engine`

## Requirements
- R1: While reset is held and right after it, status_o is 0, fl_rready_o, fl_wvalid_o, dma_req_o and start_busy_o are 0.
- R2: A start_i pulse while the engine is idle loads the length into status bits 13:0, and latches start_dir_i (0 = read, 1 = write) and start_dma_i. The new values are visible in the cycle after the pulse.
- R3: A start_i pulse while a transfer is loaded raises start_busy_o for exactly the next cycle. It leaves the length, direction and FIFO state of the loaded transfer unchanged.
- R4: In read direction, fl_rready_o is high only while the FIFO holds fewer than 64 bytes and the remaining count is non-zero. Each accepted flash byte lowers the remaining count by one, so exactly the programmed length is fetched.
- R5: In read direction, status bits 30:24 give the number of bytes held in the FIFO.
- R6: In read direction, host_rd_i pops four bytes, packed little-endian: the earliest fetched byte sits in host_rdata_o bits 7:0. A pop is ignored while fewer than four bytes are held.
- R7: In write direction, status bits 30:24 give the free space, which is 64 minus the bytes held.
- R8: In write direction, host_wr_i pushes host_wdata_i bits 7:0 first and then bits 15:8. A push is ignored if it would exceed the free space or the bytes still owed to the flash.
- R9: In write direction, fl_wvalid_o is high only while the FIFO holds data. Bytes leave on fl_wdata_o in push order, and each accepted byte lowers the remaining count by one.
- R10: With the DMA flag set, dma_req_o pulses for one cycle in two cases. In read direction it pulses each time the FIFO becomes full with 64 bytes. In write direction it pulses each time the FIFO becomes empty while at least 64 bytes are still owed. Without the flag, dma_req_o stays 0.
- R11: stop_i empties the FIFO, clears the remaining count and unloads the engine, so status_o reads 0 in the next cycle. A later start is accepted.
- R12: Once the remaining count is zero, no further flash handshakes occur. The engine stays loaded, and starts are refused until stop_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command strobe |
| start_dir_i | input | 1 | Direction: 0 read, 1 write |
| start_dma_i | input | 1 | Enable frame requests for this transfer |
| start_len_i | input | 14 | Transfer length in bytes |
| stop_i | input | 1 | Stop and clear the engine |
| start_busy_o | output | 1 | Start refused, one-cycle pulse |
| status_o | output | 32 | Bits 30:24 FIFO count or free space, bits 13:0 remaining bytes |
| dma_req_o | output | 1 | Frame request pulse |
| host_rd_i | input | 1 | Host pop of one 32-bit word |
| host_rdata_o | output | 32 | Word at the FIFO head |
| host_wr_i | input | 1 | Host push of one 16-bit halfword |
| host_wdata_i | input | 16 | Halfword to push |
| fl_rvalid_i | input | 1 | Flash read byte valid |
| fl_rdata_i | input | 8 | Flash read byte |
| fl_rready_o | output | 1 | Engine accepts a flash read byte |
| fl_wvalid_o | output | 1 | Engine offers a byte to the flash |
| fl_wdata_o | output | 8 | Byte to the flash |
| fl_wready_i | input | 1 | Flash accepts the offered byte |

## Verification
The read direction is exercised three ways:
- A host that drains as fast as bytes arrive, which shows data ordering and little-endian packing.
- A host that holds off until the FIFO fills, which shows the flash-side stall at 64 bytes.
- A host popping against a FIFO of three bytes, which shows that an underfilled pop is ignored.

The write direction is also exercised three ways:
- A flash that accepts every cycle, which shows the empty-FIFO drain gating.
- A throttled flash, which keeps the free-space field tracking near zero.
- A host that pushes past the programmed length, which shows the owed-bytes limit.

Frame requests are counted across two-frame transfers in both directions, and against transfers without the flag.

// File: rtl/nand_pf_pkg.sv
`timescale 1ns/1ps
package nand_pf_pkg;
  localparam int unsigned NPF_DEPTH    = 64;
  localparam int unsigned NPF_LEN_W    = 14;
  localparam int unsigned NPF_RD_BYTES = 4;
  localparam int unsigned NPF_WR_BYTES = 2;
  localparam int unsigned NPF_STAT_W   = 32;
  localparam int unsigned NPF_FILL_LSB = 24;

  typedef enum logic {
    XFER_RD = 1'b0,
    XFER_WR = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/nand_pf_fifo.sv
`timescale 1ns/1ps
module nand_pf_fifo #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned IN_MAX  = 2,
  parameter int unsigned OUT_MAX = 4,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = PTR_W + 1,
  localparam int unsigned IN_CW  = $clog2(IN_MAX + 1),
  localparam int unsigned OUT_CW = $clog2(OUT_MAX + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic [IN_CW-1:0]       push_cnt_i,
  input  logic [8*IN_MAX-1:0]    push_data_i,
  input  logic [OUT_CW-1:0]      pop_cnt_i,
  output logic [8*OUT_MAX-1:0]   head_o,
  output logic [CNT_W-1:0]       count_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  // storage has no reset; only pointers carry state
  always_ff @(posedge clk_i) begin
    if (!clear_i) begin
      for (int i = 0; i < int'(IN_MAX); i++) begin
        if (IN_CW'(i) < push_cnt_i) mem_q[wr_ptr_q + PTR_W'(i)] <= push_data_i[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(push_cnt_i);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_cnt_i);
      count_q  <= count_q + CNT_W'(push_cnt_i) - CNT_W'(pop_cnt_i);
    end
  end

  genvar g;
  generate
    for (g = 0; g < int'(OUT_MAX); g++) begin : g_head
      assign head_o[8*g +: 8] = mem_q[rd_ptr_q + PTR_W'(g)];
    end
  endgenerate

  assign count_o = count_q;

  p_no_overflow_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_no_underflow_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(pop_cnt_i) <= count_q);
endmodule

// File: rtl/nand_pf_ctrl.sv
`timescale 1ns/1ps
module nand_pf_ctrl import nand_pf_pkg::*; #(
  parameter int unsigned LEN_W = NPF_LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_dir_i,
  input  logic             start_dma_i,
  input  logic [LEN_W-1:0] start_len_i,
  input  logic             stop_i,
  input  logic             byte_done_i,
  output logic             active_o,
  output xfer_dir_e        dir_o,
  output logic             dma_en_o,
  output logic [LEN_W-1:0] remaining_o,
  output logic             start_busy_o
);
  logic             active_q, dma_en_q, busy_q;
  xfer_dir_e        dir_q;
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dir_q    <= XFER_RD;
      dma_en_q <= 1'b0;
      rem_q    <= '0;
      busy_q   <= 1'b0;
    end else begin
      busy_q <= start_i && active_q;
      if (stop_i) begin
        active_q <= 1'b0;
        dir_q    <= XFER_RD;
        dma_en_q <= 1'b0;
        rem_q    <= '0;
      end else if (start_i && !active_q) begin
        active_q <= 1'b1;
        dir_q    <= xfer_dir_e'(start_dir_i);
        dma_en_q <= start_dma_i;
        rem_q    <= start_len_i;
      end else if (byte_done_i && rem_q != '0) begin
        rem_q <= rem_q - LEN_W'(1);
      end
    end
  end

  assign active_o     = active_q;
  assign dir_o        = dir_q;
  assign dma_en_o     = dma_en_q;
  assign remaining_o  = rem_q;
  assign start_busy_o = busy_q;

  p_refuse_holds_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && active_q && !stop_i |=> active_q && dir_q == $past(dir_q) && dma_en_q == $past(dma_en_q));
  p_rem_no_rise_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !stop_i |=> rem_q <= $past(rem_q));
endmodule

// File: rtl/nand_pf_dma.sv
`timescale 1ns/1ps
module nand_pf_dma import nand_pf_pkg::*; #(
  parameter int unsigned DEPTH = NPF_DEPTH,
  parameter int unsigned LEN_W = NPF_LEN_W,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             dma_en_i,
  input  xfer_dir_e        dir_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [LEN_W-1:0] remaining_i,
  output logic             req_o
);
  logic frame_ok, frame_q;

  // a frame is ready: read side full, write side empty with a whole frame still owed
  always_comb begin
    frame_ok = 1'b0;
    if (active_i && dma_en_i) begin
      if (dir_i == XFER_RD) frame_ok = (fill_i == CNT_W'(DEPTH));
      else                  frame_ok = (fill_i == '0) && (remaining_i >= LEN_W'(DEPTH));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= 1'b0;
    else         frame_q <= frame_ok;
  end

  assign req_o = frame_ok && !frame_q;

  p_req_single_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
endmodule

// File: rtl/nand_pf_engine.sv
`timescale 1ns/1ps
module nand_pf_engine import nand_pf_pkg::*; #(
  parameter int unsigned DEPTH    = NPF_DEPTH,
  parameter int unsigned LEN_W    = NPF_LEN_W,
  parameter int unsigned RD_BYTES = NPF_RD_BYTES,
  parameter int unsigned WR_BYTES = NPF_WR_BYTES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    start_dir_i,
  input  logic                    start_dma_i,
  input  logic [LEN_W-1:0]        start_len_i,
  input  logic                    stop_i,
  output logic                    start_busy_o,
  output logic [NPF_STAT_W-1:0]   status_o,
  output logic                    dma_req_o,
  input  logic                    host_rd_i,
  output logic [8*RD_BYTES-1:0]   host_rdata_o,
  input  logic                    host_wr_i,
  input  logic [8*WR_BYTES-1:0]   host_wdata_i,
  input  logic                    fl_rvalid_i,
  input  logic [7:0]              fl_rdata_i,
  output logic                    fl_rready_o,
  output logic                    fl_wvalid_o,
  output logic [7:0]              fl_wdata_o,
  input  logic                    fl_wready_i
);
  localparam int unsigned CNT_W  = $clog2(DEPTH) + 1;
  localparam int unsigned IN_CW  = $clog2(WR_BYTES + 1);
  localparam int unsigned OUT_CW = $clog2(RD_BYTES + 1);
  localparam int unsigned CMP_W  = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1;
  localparam int unsigned PD_W   = 8 * WR_BYTES;

  logic             active;
  xfer_dir_e        dir;
  logic             dma_en;
  logic [LEN_W-1:0] remaining;
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] space;
  logic [8*RD_BYTES-1:0] head;
  logic             rd_mode, wr_mode;
  logic             rd_fire, wr_fire, host_pop, host_push;
  logic [IN_CW-1:0] push_cnt;
  logic [PD_W-1:0]  push_data;
  logic [OUT_CW-1:0] pop_cnt;

  nand_pf_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_dir_i  (start_dir_i),
    .start_dma_i  (start_dma_i),
    .start_len_i  (start_len_i),
    .stop_i       (stop_i),
    .byte_done_i  (rd_fire || wr_fire),
    .active_o     (active),
    .dir_o        (dir),
    .dma_en_o     (dma_en),
    .remaining_o  (remaining),
    .start_busy_o (start_busy_o)
  );

  assign rd_mode = active && (dir == XFER_RD);
  assign wr_mode = active && (dir == XFER_WR);
  assign space   = CNT_W'(DEPTH) - fill;

  // flash side
  assign fl_rready_o = rd_mode && (remaining != '0) && (fill < CNT_W'(DEPTH));
  assign rd_fire     = fl_rready_o && fl_rvalid_i;
  assign fl_wvalid_o = wr_mode && (fill != '0);
  assign fl_wdata_o  = head[7:0];
  assign wr_fire     = fl_wvalid_o && fl_wready_i;

  // host side
  assign host_pop  = rd_mode && host_rd_i && (fill >= CNT_W'(RD_BYTES));
  assign host_push = wr_mode && host_wr_i && (space >= CNT_W'(WR_BYTES)) &&
                     (CMP_W'(fill) + CMP_W'(WR_BYTES) <= CMP_W'(remaining));

  always_comb begin
    if (dir == XFER_RD) begin
      push_cnt  = rd_fire ? IN_CW'(1) : '0;
      push_data = PD_W'(fl_rdata_i);
      pop_cnt   = host_pop ? OUT_CW'(RD_BYTES) : '0;
    end else begin
      push_cnt  = host_push ? IN_CW'(WR_BYTES) : '0;
      push_data = host_wdata_i;
      pop_cnt   = wr_fire ? OUT_CW'(1) : '0;
    end
  end

  nand_pf_fifo #(.DEPTH(DEPTH), .IN_MAX(WR_BYTES), .OUT_MAX(RD_BYTES)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (stop_i),
    .push_cnt_i  (push_cnt),
    .push_data_i (push_data),
    .pop_cnt_i   (pop_cnt),
    .head_o      (head),
    .count_o     (fill)
  );

  nand_pf_dma #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dma (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .dma_en_i    (dma_en),
    .dir_i       (dir),
    .fill_i      (fill),
    .remaining_i (remaining),
    .req_o       (dma_req_o)
  );

  assign host_rdata_o = head;

  always_comb begin
    status_o = '0;
    status_o[NPF_FILL_LSB +: CNT_W] = (dir == XFER_WR) ? space : fill;
    status_o[LEN_W-1:0]             = remaining;
  end

  p_stop_clears_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> status_o == '0);
  p_done_quiet_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && remaining == '0 |-> !fl_rready_o && !fl_wvalid_o);
  p_wr_fill_bound_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |-> CMP_W'(fill) <= CMP_W'(remaining));
endmodule

// File: tb/tb_nand_pf_engine.sv
`timescale 1ns/1ps
module tb_nand_pf_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, start_dir_i = 1'b0, start_dma_i = 1'b0;
  logic [13:0] start_len_i = '0;
  logic        stop_i = 1'b0;
  logic        start_busy_o;
  logic [31:0] status_o;
  logic        dma_req_o;
  logic        host_rd_i = 1'b0;
  logic [31:0] host_rdata_o;
  logic        host_wr_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic        fl_rvalid_i = 1'b0;
  logic [7:0]  fl_rdata_i = '0;
  logic        fl_rready_o, fl_wvalid_o;
  logic [7:0]  fl_wdata_o;
  logic        fl_wready_i = 1'b0;

  nand_pf_engine dut (.*);

  always #10 clk_i = ~clk_i;

  logic [6:0]  st_cnt;
  logic [13:0] st_rem;
  assign st_cnt = status_o[30:24];
  assign st_rem = status_o[13:0];

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  int g_src, g_h, g_k, g_f, g_len, g_dma, g_bad_dma, g_mism, g_over, g_fieldbad;
  logic [7:0] g_seed;

  typedef struct packed {
    logic        dir;
    logic [13:0] len;
    logic [7:0]  seed;
    logic [7:0]  hold;
    logic [3:0]  wdiv;
    logic [6:0]  exp_field;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 14'd16,  8'h11, 8'd0,  4'd1, 7'd0},
    '{1'b0, 14'd100, 8'h5a, 8'd90, 4'd1, 7'd0},
    '{1'b0, 14'd4,   8'hf0, 8'd3,  4'd1, 7'd0},
    '{1'b1, 14'd20,  8'h22, 8'd0,  4'd1, 7'd64},
    '{1'b1, 14'd130, 8'h7c, 8'd0,  4'd3, 7'd64},
    '{1'b1, 14'd2,   8'h09, 8'd0,  4'd2, 7'd64}
  };

  function automatic logic [7:0] pat(input logic [7:0] s, input int i);
    return s + 8'(i * 13) + 8'(i >> 4);
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] s, input int i);
    return {pat(s, i + 3), pat(s, i + 2), pat(s, i + 1), pat(s, i)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_globals(input logic [7:0] seed, input int len);
    g_seed = seed; g_len = len;
    g_src = 0; g_h = 0; g_k = 0; g_f = 0;
    g_dma = 0; g_bad_dma = 0; g_mism = 0; g_over = 0; g_fieldbad = 0;
  endtask

  task automatic start_cmd(input logic dir, input int len, input logic dma);
    start_i = 1'b1; start_dir_i = dir; start_len_i = 14'(len); start_dma_i = dma;
    @(negedge clk_i);
    start_i = 1'b0; start_dma_i = 1'b0;
  endtask

  task automatic stop_cmd();
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    chk(status_o == 32'd0, "R11", "status after stop", status_o, 32'd0);
  endtask

  // one cycle of read traffic; called and returns at a falling edge
  task automatic rd_step(input bit want_rd);
    fl_rdata_i = pat(g_seed, g_src);
    if (fl_rready_o && fl_rvalid_i) g_src++;
    if (fl_rready_o && st_cnt == 7'd64) g_over++;
    if (dma_req_o) begin
      g_dma++;
      if (st_cnt != 7'd64) g_bad_dma++;
    end
    if (want_rd && st_cnt >= 7'd4) begin
      host_rd_i = 1'b1;
      if (host_rdata_o != exp_word(g_seed, g_h)) g_mism++;
      g_h += 4;
    end else host_rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  // one cycle of write traffic
  task automatic wr_step(input bit want_push, input bit wready);
    int occ;
    occ = g_k - g_f;
    if (st_cnt != 7'(64 - occ)) g_fieldbad++;
    if (fl_wvalid_o && occ == 0) g_over++;
    fl_wready_i = wready;
    if (fl_wvalid_o && wready) begin
      if (fl_wdata_o != pat(g_seed, g_f)) g_mism++;
      g_f++;
    end
    if (dma_req_o) g_dma++;
    if (want_push && g_k < g_len && (64 - occ) >= 2) begin
      host_wr_i = 1'b1;
      host_wdata_i = {pat(g_seed, g_k + 1), pat(g_seed, g_k)};
      g_k += 2;
    end else host_wr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic run_read(input vec_t v);
    int cyc;
    clr_globals(v.seed, int'(v.len));
    start_cmd(1'b0, int'(v.len), 1'b0);
    chk(st_rem == v.len, "R2", "read length loaded", 32'(st_rem), 32'(v.len));
    chk(st_cnt == v.exp_field, "R5", "read fill after start", 32'(st_cnt), 32'(v.exp_field));
    fl_rvalid_i = 1'b1;
    cyc = 0;
    while (g_h < int'(v.len) && cyc < 3000) begin
      if (v.hold >= 8'd70 && cyc == int'(v.hold)) begin
        chk(st_cnt == 7'd64, "R5", "read fill when full", 32'(st_cnt), 32'd64);
        chk(!fl_rready_o && st_rem == v.len - 14'd64, "R4", "flash stalls at full",
            32'(st_rem), 32'(v.len - 14'd64));
      end
      rd_step(cyc >= int'(v.hold));
      cyc++;
    end
    host_rd_i = 1'b0; fl_rvalid_i = 1'b0;
    chk(g_mism == 0, "R6", "little-endian read words", 32'(g_mism), 32'd0);
    chk(g_src == int'(v.len) && g_over == 0, "R4", "bytes fetched", 32'(g_src), 32'(v.len));
    chk(st_rem == 14'd0 && st_cnt == 7'd0 && !fl_rready_o, "R12", "read done quiet",
        status_o, 32'd0);
    chk(g_dma == 0, "R10", "no request without flag", 32'(g_dma), 32'd0);
    stop_cmd();
  endtask

  task automatic run_write(input vec_t v);
    int cyc;
    clr_globals(v.seed, int'(v.len));
    start_cmd(1'b1, int'(v.len), 1'b0);
    chk(st_rem == v.len, "R2", "write length loaded", 32'(st_rem), 32'(v.len));
    chk(st_cnt == v.exp_field, "R7", "free space after start", 32'(st_cnt), 32'(v.exp_field));
    cyc = 0;
    while (g_f < int'(v.len) && cyc < 3000) begin
      wr_step(1'b1, (cyc % int'(v.wdiv)) == 0);
      cyc++;
    end
    host_wr_i = 1'b0; fl_wready_i = 1'b0;
    chk(g_mism == 0, "R8", "flash byte order", 32'(g_mism), 32'd0);
    chk(g_fieldbad == 0, "R7", "free space tracking", 32'(g_fieldbad), 32'd0);
    chk(g_over == 0, "R9", "no drain from empty fifo", 32'(g_over), 32'd0);
    chk(st_rem == 14'd0 && !fl_wvalid_o, "R12", "write done quiet", 32'(st_rem), 32'd0);
    chk(g_dma == 0, "R10", "no request without flag", 32'(g_dma), 32'd0);
    stop_cmd();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(status_o == 0 && !fl_rready_o && !fl_wvalid_o && !dma_req_o && !start_busy_o,
        "R1", "outputs in reset", status_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(status_o == 0 && !fl_rready_o && !fl_wvalid_o && !dma_req_o && !start_busy_o,
        "R1", "outputs after reset", status_o, 32'd0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].dir == 1'b0) run_read(VECS[v]);
      else                     run_write(VECS[v]);
    end

    // R3: refused start keeps the loaded read transfer
    start_cmd(1'b0, 16, 1'b0);
    start_cmd(1'b1, 40, 1'b1);
    chk(start_busy_o == 1'b1, "R3", "busy pulse", 32'(start_busy_o), 32'd1);
    chk(st_rem == 14'd16 && st_cnt == 7'd0 && fl_rready_o, "R3", "transfer untouched",
        status_o, 32'd16);
    @(negedge clk_i);
    chk(start_busy_o == 1'b0, "R3", "busy lasts one cycle", 32'(start_busy_o), 32'd0);
    stop_cmd();

    // R6: pop with three bytes held is ignored
    clr_globals(8'h3c, 8);
    start_cmd(1'b0, 8, 1'b0);
    fl_rvalid_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      fl_rdata_i = pat(g_seed, i);
      @(negedge clk_i);
    end
    fl_rvalid_i = 1'b0;
    chk(st_cnt == 7'd3, "R5", "fill of three", 32'(st_cnt), 32'd3);
    host_rd_i = 1'b1;
    @(negedge clk_i);
    host_rd_i = 1'b0;
    chk(st_cnt == 7'd3 && st_rem == 14'd5, "R6", "short pop ignored", 32'(st_cnt), 32'd3);
    fl_rvalid_i = 1'b1; fl_rdata_i = pat(g_seed, 3);
    @(negedge clk_i);
    fl_rvalid_i = 1'b0;
    chk(host_rdata_o == exp_word(g_seed, 0), "R6", "packed word", host_rdata_o, exp_word(g_seed, 0));
    host_rd_i = 1'b1;
    @(negedge clk_i);
    host_rd_i = 1'b0;
    chk(st_cnt == 7'd0, "R6", "pop of four", 32'(st_cnt), 32'd0);
    stop_cmd();

    // R8: push past the programmed length is ignored; R12: refused after completion
    clr_globals(8'h81, 4);
    start_cmd(1'b1, 4, 1'b0);
    host_wr_i = 1'b1;
    host_wdata_i = {pat(g_seed, 1), pat(g_seed, 0)};
    @(negedge clk_i);
    host_wdata_i = {pat(g_seed, 3), pat(g_seed, 2)};
    @(negedge clk_i);
    host_wdata_i = 16'hddee;
    @(negedge clk_i);
    host_wr_i = 1'b0;
    chk(st_cnt == 7'd60, "R8", "extra push ignored", 32'(st_cnt), 32'd60);
    g_k = 4;
    for (int i = 0; i < 8; i++) wr_step(1'b0, 1'b1);
    fl_wready_i = 1'b0;
    chk(g_f == 4 && g_mism == 0, "R9", "exactly four bytes posted", 32'(g_f), 32'd4);
    chk(st_rem == 14'd0 && !fl_wvalid_o, "R12", "write drained", 32'(st_rem), 32'd0);
    start_cmd(1'b0, 8, 1'b0);
    chk(start_busy_o == 1'b1 && st_cnt == 7'd64, "R12", "start refused until stop",
        32'(start_busy_o), 32'd1);
    stop_cmd();

    // R10: read frames
    clr_globals(8'h47, 128);
    start_cmd(1'b0, 128, 1'b1);
    fl_rvalid_i = 1'b1;
    repeat (70) rd_step(1'b0);
    chk(g_dma == 1, "R10", "first read frame", 32'(g_dma), 32'd1);
    for (int c = 0; c < 500 && g_h < 64; c++) rd_step(1'b1);
    repeat (80) rd_step(1'b0);
    for (int c = 0; c < 500 && g_h < 128; c++) rd_step(1'b1);
    fl_rvalid_i = 1'b0; host_rd_i = 1'b0;
    chk(g_dma == 2 && g_bad_dma == 0, "R10", "read frame requests", 32'(g_dma), 32'd2);
    chk(g_mism == 0, "R6", "read data across frames", 32'(g_mism), 32'd0);
    stop_cmd();

    // R10: write frames
    clr_globals(8'hb3, 128);
    start_cmd(1'b1, 128, 1'b1);
    chk(dma_req_o == 1'b1, "R10", "request at write start", 32'(dma_req_o), 32'd1);
    repeat (40) wr_step(1'b1, 1'b0);
    chk(st_cnt == 7'd0, "R7", "write fifo full", 32'(st_cnt), 32'd0);
    for (int c = 0; c < 500 && g_f < 64; c++) wr_step(1'b0, 1'b1);
    for (int c = 0; c < 1000 && g_f < 128; c++) wr_step(1'b1, 1'b1);
    repeat (4) wr_step(1'b0, 1'b0);
    chk(g_dma == 2, "R10", "write frame requests", 32'(g_dma), 32'd2);
    chk(g_mism == 0 && g_fieldbad == 0, "R9", "write data across frames", 32'(g_mism), 32'd0);
    stop_cmd();

    // R11: stop mid transfer, then a new start is taken
    clr_globals(8'h10, 40);
    start_cmd(1'b0, 40, 1'b0);
    fl_rvalid_i = 1'b1;
    repeat (10) rd_step(1'b0);
    fl_rvalid_i = 1'b0;
    stop_cmd();
    chk(!fl_rready_o, "R11", "flash idle after stop", 32'(fl_rready_o), 32'd0);
    start_cmd(1'b1, 6, 1'b0);
    chk(!start_busy_o && st_rem == 14'd6 && st_cnt == 7'd64, "R11", "start after stop",
        status_o, 32'h4000_0006);
    stop_cmd();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule